// File: doc/BRIEF.md
# Line-Fill Controller with Bus-Error Abort

This controller services a read miss by fetching a cache line as four long-word beats from an external bus. It starts the fetch at the requested long word and wraps around the line from there. Each incoming long word is held in a small line buffer. The cache is written once, with the whole line, and only after the last beat completes cleanly. If the victim line is dirty, it is first handed to a push buffer. The fetch does not begin until the push buffer accepts the victim. A single-beat write access runs through the same bus handshake.

A transfer-error on any beat ends the fetch at once. The remaining beats are abandoned, the cache is not written, and the old line stays in place. The controller then raises a one-cycle exception strobe toward the execution unit, but only in these cases:

- the failing beat carried the long word that was requested;
- the failing beat carried the second half of an operand that crosses into the next long word;
- the failing access was a write.

Errors on prefetched words that nobody asked for are dropped silently. The next miss to the same line simply starts a new fetch.

States: `S_IDLE` (accepting requests), `S_PUSH` (offering the dirty victim), `S_FILL` (running read beats), `S_COMMIT` (one-cycle cache write), `S_WRITE` (single write beat). Transitions:

| From | To | Condition |
|---|---|---|
| `S_IDLE` | `S_WRITE` | request for a write |
| `S_IDLE` | `S_PUSH` | read request with a dirty valid victim |
| `S_IDLE` | `S_FILL` | read request with a clean or invalid victim |
| `S_PUSH` | `S_FILL` | push buffer not full |
| `S_FILL` | `S_IDLE` | transfer error (abort) |
| `S_FILL` | `S_COMMIT` | acknowledge on the fourth beat |
| `S_COMMIT` | `S_IDLE` | always |
| `S_WRITE` | `S_IDLE` | acknowledge or error |

Top module: `linefill_ctrl`

## Requirements
- R1: After reset the controller is idle: req_ready is 1, and bus_req, bus_wr, push_valid, cache_we and exc_pulse are all 0.
- R2: The read beats present bus_word = (req_word + k) mod 4 for k = 0,1,2,3, in that order. bus_word holds its value through cycles with neither acknowledge nor error.
- R3: Acknowledge on the fourth beat is followed, in the next cycle, by exactly one cycle of cache_we. In that cycle cache_line bits [32*i+31:32*i] hold the data received for long word i.
- R4: A transfer error on any read beat drops bus_req in the next cycle. No further beat is issued, and cache_we is not asserted for that fill.
- R5: A transfer error on the first read beat (the requested long word) gives exc_pulse high for exactly one cycle, in the cycle after the error.
- R6: A transfer error on read beats two to four gives no exc_pulse, unless R7 applies.
- R7: An operand crosses a long-word boundary when req_off + bytes > 4, where req_size 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. For such an operand, an error on the second read beat also raises exc_pulse.
- R8: A read request whose victim is valid and dirty first holds push_valid high, with bus_req low, for as long as push_full is 1. The first read beat appears in the cycle after the push is accepted. A clean or invalid victim gives no push_valid.
- R9: A dirty victim is pushed exactly once per read request, whether or not the fill that follows is aborted.
- R10: A write request issues one beat with bus_req=1, bus_wr=1 and bus_word=req_word. An error on it raises exc_pulse in the next cycle, an acknowledge does not, and cache_we stays 0.
- R11: A beat with acknowledge and error both high is treated as an error.
- R12: req_ready is 1 exactly in the idle state. A new request is accepted in the same cycle that exc_pulse reports the previous abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss or write request |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | Request is a single write access |
| req_word | input | 2 | Requested long-word index in the line |
| req_size | input | 2 | Operand size code (0:1B, 1:2B, 2/3:4B) |
| req_off | input | 2 | Byte offset of the operand within the long word |
| victim_valid | input | 1 | Line being replaced is valid |
| victim_dirty | input | 1 | Line being replaced is dirty |
| push_valid | output | 1 | Victim offered to the push buffer |
| push_full | input | 1 | Push buffer cannot accept |
| bus_req | output | 1 | Bus beat requested |
| bus_wr | output | 1 | Current beat is a write |
| bus_word | output | 2 | Long-word index of the current beat |
| bus_ta | input | 1 | Transfer acknowledge |
| bus_tea | input | 1 | Transfer error |
| bus_data | input | 32 | Read data of the current beat |
| cache_we | output | 1 | Write the assembled line into the cache |
| cache_line | output | 128 | Assembled line, long word i at bits 32*i+31:32*i |
| exc_pulse | output | 1 | Access-error exception strobe |

## Verification
Two events can land on the same cycle. The one-cycle exception strobe for an aborted fill falls on the first idle cycle, which is also a cycle in which the controller may accept its next request. The bench provokes this by driving a new request in the very cycle after an error on the requested word. It then checks three things: exc_pulse and req_ready are both high in that cycle, the strobe is gone one cycle later, and the new fill's first beat is on the bus at that point. A second overlap, acknowledge and error raised on the same beat, is swept across every beat position and judged as an abort.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_FILL,
        S_COMMIT,
        S_WRITE
    } lf_state_t;

    // Operand crosses into the next long word when offset + bytes exceeds 4
    function automatic logic crosses_word(input logic [1:0] size, input logic [1:0] off);
        logic [3:0] nbytes;
        nbytes = (size == 2'd0) ? 4'd1 : (size == 2'd1) ? 4'd2 : 4'd4;
        return ({2'b00, off} + nbytes) > 4'd4;
    endfunction

endpackage

// File: rtl/lf_beat_ctr.sv
module lf_beat_ctr #(
    parameter int NBEAT = 4,
    localparam int IW = $clog2(NBEAT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [IW-1:0] base,
    output logic [IW-1:0] word,
    output logic          last
);
    logic [IW-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            beat_q <= '0;
        else if (clr)
            beat_q <= '0;
        else if (adv)
            beat_q <= beat_q + 1'b1;
    end

    assign word = base + beat_q;
    assign last = (beat_q == IW'(NBEAT - 1));

    // R2
    beat_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (beat_q == IW'($past(beat_q) + 1'b1)));

endmodule

// File: rtl/lf_line_buf.sv
module lf_line_buf #(
    parameter int DW    = 32,
    parameter int NBEAT = 4,
    localparam int IW = $clog2(NBEAT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wr_data,
    output logic [NBEAT*DW-1:0] line
);
    for (genvar i = 0; i < NBEAT; i++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr_en && wr_idx == IW'(i))
                slot_q <= wr_data;
        end
        assign line[i*DW +: DW] = slot_q;
    end
endmodule

// File: rtl/lf_err_judge.sv
module lf_err_judge #(
    parameter int NBEAT = 4,
    localparam int IW = $clog2(NBEAT)
) (
    input  logic          is_write,
    input  logic          crosses,
    input  logic [IW-1:0] beat_word,
    input  logic [IW-1:0] want_word,
    output logic          raise
);
    logic hits_want;
    logic hits_tail;

    always_comb begin
        hits_want = (beat_word == want_word);
        hits_tail = crosses && (beat_word == IW'(want_word + 1'b1));
        raise     = is_write || hits_want || hits_tail;
    end
endmodule

// File: rtl/linefill_ctrl.sv
module linefill_ctrl
    import lf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NBEAT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [$clog2(NBEAT)-1:0]    req_word,
    input  logic [1:0]                  req_size,
    input  logic [1:0]                  req_off,
    input  logic                        victim_valid,
    input  logic                        victim_dirty,
    output logic                        push_valid,
    input  logic                        push_full,
    output logic                        bus_req,
    output logic                        bus_wr,
    output logic [$clog2(NBEAT)-1:0]    bus_word,
    input  logic                        bus_ta,
    input  logic                        bus_tea,
    input  logic [DW-1:0]               bus_data,
    output logic                        cache_we,
    output logic [NBEAT*DW-1:0]         cache_line,
    output logic                        exc_pulse
);
    localparam int IW = $clog2(NBEAT);

    lf_state_t     state_q, state_d;
    logic [IW-1:0] word_q;
    logic          span_q;
    logic          wr_q;
    logic          exc_q;
    logic          accept;
    logic          beat_ok;
    logic          beat_err;
    logic          last_beat;
    logic [IW-1:0] cur_word;
    logic          raise;

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign beat_err = ((state_q == S_FILL) || (state_q == S_WRITE)) && bus_tea;
    assign beat_ok  = (state_q == S_FILL) && bus_ta && !bus_tea;

    lf_beat_ctr #(.NBEAT(NBEAT)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .adv  (beat_ok),
        .base (word_q),
        .word (cur_word),
        .last (last_beat)
    );

    lf_line_buf #(.DW(DW), .NBEAT(NBEAT)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (beat_ok),
        .wr_idx (cur_word),
        .wr_data(bus_data),
        .line   (cache_line)
    );

    lf_err_judge #(.NBEAT(NBEAT)) u_judge (
        .is_write (wr_q),
        .crosses  (span_q),
        .beat_word(cur_word),
        .want_word(word_q),
        .raise    (raise)
    );

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            word_q  <= '0;
            span_q  <= 1'b0;
            wr_q    <= 1'b0;
            exc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            exc_q   <= beat_err && raise;
            if (accept) begin
                word_q <= req_word;
                span_q <= crosses_word(req_size, req_off);
                wr_q   <= req_write;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_write)
                        state_d = S_WRITE;
                    else if (victim_valid && victim_dirty)
                        state_d = S_PUSH;
                    else
                        state_d = S_FILL;
                end
            end
            S_PUSH:   if (!push_full) state_d = S_FILL;
            S_FILL: begin
                if (bus_tea)
                    state_d = S_IDLE;
                else if (bus_ta && last_beat)
                    state_d = S_COMMIT;
            end
            S_COMMIT: state_d = S_IDLE;
            S_WRITE:  if (bus_ta || bus_tea) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        push_valid = 1'b0;
        bus_req    = 1'b0;
        bus_wr     = 1'b0;
        bus_word   = cur_word;
        cache_we   = 1'b0;
        unique case (state_q)
            S_IDLE:   req_ready  = 1'b1;
            S_PUSH:   push_valid = 1'b1;
            S_FILL:   bus_req    = 1'b1;
            S_COMMIT: cache_we   = 1'b1;
            S_WRITE: begin
                bus_req  = 1'b1;
                bus_wr   = 1'b1;
                bus_word = word_q;
            end
            default: ;
        endcase
    end

    assign exc_pulse = exc_q;

    // R4
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && bus_tea) |=> (state_q == S_IDLE && !cache_we));

    // R5
    exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |=> !exc_pulse);

    // R3
    commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && bus_ta && !bus_tea && last_beat) |=> cache_we);

    // R8
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_full) |=> (push_valid && !bus_req));

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && !bus_ta && !bus_tea) |=> $stable(bus_word));

    // R12
    one_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, push_valid, bus_req, cache_we}));

endmodule

// File: tb/tb_linefill_ctrl.sv
module tb_linefill_ctrl;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         req_valid = 0, req_write = 0;
    logic [1:0]   req_word = 0, req_size = 0, req_off = 0;
    logic         victim_valid = 0, victim_dirty = 0, push_full = 0;
    logic         bus_ta = 0, bus_tea = 0;
    logic [31:0]  bus_data = 0;
    logic         req_ready, push_valid, bus_req, bus_wr, cache_we, exc_pulse;
    logic [1:0]   bus_word;
    logic [127:0] cache_line;

    int total = 0, bad = 0, pushes = 0, dirty_reqs = 0, run = 0, cycles = 0;

    always #5 clk = ~clk;

    linefill_ctrl dut (.*);

    always @(posedge clk) begin
        cycles++;
        if (push_valid && !push_full) pushes++;
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dat(input int r, input int idx);
        return {r[15:0], 8'hC5, 6'd0, idx[1:0]};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input int w, input int sz, input int off, input bit dirty, input bit wr);
        req_valid = 1; req_word = w[1:0]; req_size = sz[1:0]; req_off = off[1:0];
        req_write = wr; victim_valid = 1; victim_dirty = dirty;
        chk(req_ready === 1'b1, "R12 ready in idle", req_ready, 1);
        step();
        req_valid = 0;
    endtask

    task automatic beats(input int w, input int eb, input bit both, input bit span, input int chain);
        for (int b = 0; b < 4; b++) begin
            chk(bus_req === 1'b1 && bus_wr === 1'b0, "R2 read beat", {bus_req, bus_wr}, 2'b10);
            chk(bus_word === 2'((w + b) % 4), "R2 beat word", bus_word, (w + b) % 4);
            if (b == 2) begin
                step();
                chk(bus_word === 2'((w + b) % 4), "R2 word held in wait", bus_word, (w + b) % 4);
            end
            bus_data = dat(run, (w + b) % 4);
            if (b == eb) begin
                bus_tea = 1; bus_ta = both;
            end else
                bus_ta = 1;
            step();
            bus_ta = 0; bus_tea = 0;
            if (b == eb) begin
                chk(bus_req === 1'b0, "R4 beats stop after error", bus_req, 0);
                chk(cache_we === 1'b0, "R4 no cache write on abort", cache_we, 0);
                chk(exc_pulse === ((eb == 0) || (span && eb == 1)),
                    both ? "R11 ta+tea judged as error" : (eb == 0 ? "R5 exception on requested word" :
                    (span && eb == 1) ? "R7 exception on crossing word" : "R6 no exception on prefetch"),
                    exc_pulse, (eb == 0) || (span && eb == 1));
                if (chain >= 0) begin
                    issue(chain, 2, 0, 0, 0);
                    chk(exc_pulse === 1'b0, "R5 strobe lasts one cycle", exc_pulse, 0);
                    run++;
                    beats(chain, 4, 0, 0, -1);
                end else begin
                    step();
                    chk(exc_pulse === 1'b0 && cache_we === 1'b0, "R5 strobe lasts one cycle",
                        {exc_pulse, cache_we}, 0);
                end
                return;
            end
        end
        chk(cache_we === 1'b1, "R3 commit after fourth beat", cache_we, 1);
        for (int i = 0; i < 4; i++)
            chk(cache_line[i*32 +: 32] === dat(run, i), "R3 line contents", cache_line[i*32 +: 32], dat(run, i));
        step();
        chk(cache_we === 1'b0 && exc_pulse === 1'b0, "R3 single commit", {cache_we, exc_pulse}, 0);
    endtask

    task automatic run_fill(input int w, input int sz, input int off, input bit dirty, input int eb,
                            input bit both, input int stall);
        bit span;
        int bytes;
        bytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        span = (off + bytes) > 4;
        run++;
        if (dirty) dirty_reqs++;
        issue(w, sz, off, dirty, 0);
        if (dirty) begin
            for (int s = 0; s <= stall; s++) begin
                push_full = (s < stall);
                chk(push_valid === 1'b1 && bus_req === 1'b0, "R8 push before fill", {push_valid, bus_req}, 2'b10);
                step();
            end
            push_full = 0;
        end else
            chk(push_valid === 1'b0, "R8 no push for clean victim", push_valid, 0);
        beats(w, eb, both, span, -1);
    endtask

    task automatic run_write(input int w, input bit err);
        issue(w, 2, 0, 1, 1);
        chk(bus_req === 1'b1 && bus_wr === 1'b1 && bus_word === w[1:0] && push_valid === 1'b0,
            "R10 write beat", {bus_req, bus_wr, bus_word}, {2'b11, w[1:0]});
        bus_tea = err; bus_ta = !err;
        step();
        bus_ta = 0; bus_tea = 0;
        chk(exc_pulse === err && cache_we === 1'b0, "R10 write error strobe", {exc_pulse, cache_we}, {err, 1'b0});
        step();
        chk(exc_pulse === 1'b0, "R10 strobe ends", exc_pulse, 0);
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=0", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int szs[4] = '{2, 1, 0, 2};
        int ofs[4] = '{0, 3, 3, 1};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready === 1'b1 && {bus_req, bus_wr, push_valid, cache_we, exc_pulse} === 5'b0,
            "R1 reset state", {req_ready, bus_req, bus_wr, push_valid, cache_we, exc_pulse}, 6'b100000);
        for (int w = 0; w < 4; w++)
            for (int c = 0; c < 4; c++)
                for (int eb = 0; eb <= 4; eb++)
                    for (int d = 0; d < 2; d++)
                        run_fill(w, szs[c], ofs[c], d[0], eb, ((eb + w) % 2) == 1, (w + eb) % 3);
        chk(pushes == dirty_reqs, "R9 one push per dirty request", pushes, dirty_reqs);
        for (int w = 0; w < 4; w++)
            for (int e = 0; e < 2; e++)
                run_write(w, e[0]);
        // R12: request accepted in the cycle of the strobe
        run++;
        issue(1, 2, 0, 0, 0);
        beats(1, 0, 0, 0, 3);
        chk(pushes == dirty_reqs, "R9 no push from writes or clean fills", pushes, dirty_reqs);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule